// File: doc/BRIEF.md
# External Interrupt Request Controller

This block is the front end for eight external interrupt pins. Each pin is brought into the clock domain through a synchroniser. It is then compared against a detection mode chosen per channel: low level, high level, rising edge or falling edge. A matching event latches that channel's request flag. The flag stays set until it is cleared. A channel's request line to the CPU is high only while both its flag and its enable bit are set.

Software reaches the block over a simple byte-wide bus with an address, a write strobe, write data and combinational read data. Software clears a flag by writing 0 to its bit position; a 1 in that position leaves the flag as it is. This lets a handler clear only the channels it has serviced. A data-transfer engine can also clear a flag. It pulses a done strobe together with a channel number each time it finishes moving one data item for that channel.

Top module: `ext_irq_ctrl`

## Requirements
- R1: While reset is asserted, every flag, enable bit and mode-select bit reads 0 and every request output is 0.
- R2: Mode 00 (low level) and mode 01 (high level) set the flag on every cycle that the synchronised input sits at the active level, so a flag cleared while the level persists is set again.
- R3: Mode 10 (rising edge) sets the flag only on a 0-to-1 change of the synchronised input, and mode 11 (falling edge) only on a 1-to-0 change. An edge of the other direction leaves the flag alone, and a flag never becomes 1 without a detected event.
- R4: Once set, a flag keeps its value until a software clear or a transfer completion removes it.
- R5: A write to the flag byte clears each flag whose data bit is 0 and leaves unchanged each flag whose data bit is 1.
- R6: A cycle with `xfer_done` high clears the flag of channel `xfer_chan` only; the other channels are unaffected.
- R7: When a set event and a clear (software or transfer) hit the same channel in the same cycle, the flag ends up set.
- R8: `irq_req[i]` is 1 exactly when flag i and enable bit i are both 1.
- R9: Address 0 holds the enable byte (bit i is channel i). Address 1 holds the flag byte. Address 2 holds the mode selects of channels 0 to 3, and address 3 holds those of channels 4 to 7, two bits per channel with channel i at bits [2(i mod 4)+1 : 2(i mod 4)]. Reads return the current contents.
- R10: A change on a pin first affects its flag at the third rising clock edge after the change: two synchroniser stages plus the flag register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin | input | 8 | Asynchronous external interrupt inputs, one per channel |
| bus_addr | input | 2 | Register byte address |
| bus_we | input | 1 | Write strobe, one write per cycle when high |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| xfer_done | input | 1 | Transfer engine finished one data item |
| xfer_chan | input | 3 | Channel that the completed transfer belongs to |
| irq_req | output | 8 | Per-channel interrupt request to the CPU |

## Verification
The bound checker watches the flag bank on every cycle. A flag may fall only after a clear, may rise only after a detected event, and cannot drop while an event coincides with a clear. A request may never be high without both its flag and its enable bit. The scenarios in the bench are what show the encoding of the four detection modes, the register address map, the bit-wise write-0 clear, auto-clear steering by channel number, the exact three-edge pin-to-flag latency and the level-mode re-set after a clear.

// File: rtl/eic_pkg.sv
package eic_pkg;

  typedef enum logic [1:0] {
    DET_LOW  = 2'b00,
    DET_HIGH = 2'b01,
    DET_RISE = 2'b10,
    DET_FALL = 2'b11
  } det_mode_e;

  localparam int ADDR_EN   = 0;
  localparam int ADDR_FLAG = 1;
  localparam int ADDR_SEL0 = 2;

  // Event for one channel from its mode and two successive synchronised samples
  function automatic logic det_hit(det_mode_e mode, logic cur, logic prev);
    logic hit;
    unique case (mode)
      DET_LOW:  hit = ~cur;
      DET_HIGH: hit = cur;
      DET_RISE: hit = cur & ~prev;
      DET_FALL: hit = ~cur & prev;
      default:  hit = 1'b0;
    endcase
    return hit;
  endfunction

  // Software clear: only a zero bit written to the flag byte clears
  function automatic logic sw_clear(logic flag_write, logic wbit);
    return flag_write & ~wbit;
  endfunction

  // Next flag value; a set event overrides any clear in the same cycle
  function automatic logic flag_next(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic sync_o,
  output logic prev_o
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= RST_VAL;
        else        chain_q <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign sync_o = chain_q[STAGES-1];
  assign prev_o = prev_q;

endmodule

// File: rtl/eic_chan.sv
module eic_chan import eic_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin,
  input  det_mode_e mode,
  output logic      hit
);

  logic cur_s;
  logic prev_s;

  eic_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (pin),
    .sync_o (cur_s),
    .prev_o (prev_s)
  );

  assign hit = det_hit(mode, cur_s, prev_s);

endmodule

// File: rtl/eic_cfg.sv
module eic_cfg import eic_pkg::*; #(
  parameter int NCH = 8,
  parameter int AW  = 2,
  localparam int SEL_W     = 2 * NCH,
  localparam int SEL_BYTES = SEL_W / NCH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [NCH-1:0]   wdata,
  output logic [NCH-1:0]   en_q,
  output logic [SEL_W-1:0] sel_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           en_q <= '0;
    else if (we && addr == AW'(ADDR_EN))  en_q <= wdata;
  end

  logic [NCH-1:0] sel_byte_q [SEL_BYTES];

  generate
    for (genvar k = 0; k < SEL_BYTES; k++) begin : g_sel
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  sel_byte_q[k] <= '0;
        else if (we && addr == AW'(ADDR_SEL0 + k))   sel_byte_q[k] <= wdata;
      end
      assign sel_q[k*NCH +: NCH] = sel_byte_q[k];
    end
  endgenerate

endmodule

// File: rtl/eic_flags.sv
module eic_flags import eic_pkg::*; #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set_vec,
  input  logic [NCH-1:0] clr_vec,
  output logic [NCH-1:0] flag_q
);

  logic [NCH-1:0] flag_d;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      flag_d[i] = flag_next(flag_q[i], set_vec[i], clr_vec[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl import eic_pkg::*; #(
  parameter int NCH         = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CHW       = $clog2(NCH),
  localparam int SEL_W     = 2 * NCH,
  localparam int SEL_BYTES = SEL_W / NCH,
  localparam int AW        = $clog2(ADDR_SEL0 + SEL_BYTES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  irq_pin,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic [NCH-1:0]  bus_wdata,
  output logic [NCH-1:0]  bus_rdata,
  input  logic            xfer_done,
  input  logic [CHW-1:0]  xfer_chan,
  output logic [NCH-1:0]  irq_req
);

  logic [NCH-1:0]   en_q;
  logic [SEL_W-1:0] sel_q;
  logic [NCH-1:0]   flag_q;
  logic [NCH-1:0]   set_vec;
  logic [NCH-1:0]   sw_clr;
  logic [NCH-1:0]   auto_clr;
  logic [NCH-1:0]   clr_vec;
  logic             flag_write;

  eic_cfg #(
    .NCH (NCH),
    .AW  (AW)
  ) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (bus_we),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .en_q  (en_q),
    .sel_q (sel_q)
  );

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      det_mode_e mode_i;
      assign mode_i = det_mode_e'(sel_q[2*i +: 2]);

      eic_chan #(
        .SYNC_STAGES (SYNC_STAGES)
      ) u_chan (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (irq_pin[i]),
        .mode  (mode_i),
        .hit   (set_vec[i])
      );

      assign sw_clr[i]   = sw_clear(flag_write, bus_wdata[i]);
      assign auto_clr[i] = xfer_done && (xfer_chan == CHW'(i));
    end
  endgenerate

  assign flag_write = bus_we && (bus_addr == AW'(ADDR_FLAG));
  assign clr_vec    = sw_clr | auto_clr;

  eic_flags #(
    .NCH (NCH)
  ) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .flag_q  (flag_q)
  );

  assign irq_req = flag_q & en_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(ADDR_EN))   bus_rdata = en_q;
    if (bus_addr == AW'(ADDR_FLAG)) bus_rdata = flag_q;
    for (int k = 0; k < SEL_BYTES; k++) begin
      if (bus_addr == AW'(ADDR_SEL0 + k)) bus_rdata = sel_q[k*NCH +: NCH];
    end
  end

endmodule

// File: rtl/eic_chk.sv
module eic_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] flag_q,
  input logic [NCH-1:0] en_q,
  input logic [NCH-1:0] set_vec,
  input logic [NCH-1:0] clr_vec,
  input logic [NCH-1:0] irq_req
);

  assert_reset_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (flag_q == '0 && en_q == '0 && irq_req == '0));

  // A flag becomes 1 only one cycle after its detector reported an event (R3)
  assert_set_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((flag_q & ~$past(flag_q) & ~$past(set_vec)) == '0));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (($past(flag_q) & ~$past(clr_vec) & ~flag_q) == '0));

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (($past(clr_vec) & ~$past(set_vec) & flag_q) == '0));

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (($past(set_vec) & ~flag_q) == '0));

  assert_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_req & ~flag_q) == '0) && ((irq_req & ~en_q) == '0));

endmodule

bind ext_irq_ctrl eic_chk #(.NCH(NCH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .flag_q  (flag_q),
  .en_q    (en_q),
  .set_vec (set_vec),
  .clr_vec (clr_vec),
  .irq_req (irq_req)
);

// File: tb/ext_irq_ctrl_test.sv
`timescale 1ns/1ps
module ext_irq_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_pin = 8'hFF;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       xfer_done = 1'b0;
  logic [2:0] xfer_chan = 3'd0;
  logic [7:0] irq_req;

  always #2.5 clk = ~clk;

  ext_irq_ctrl uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_pin   (irq_pin),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .xfer_done (xfer_done),
    .xfer_chan (xfer_chan),
    .irq_req   (irq_req)
  );

  typedef struct {
    bit         is_irq;
    logic [7:0] exp;
    string      tag;
  } exp_item_t;

  exp_item_t sb_q[$];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Monitor: pops each expected item and compares at the falling edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_item_t it;
      logic [7:0] act;
      it = sb_q.pop_front();
      act = it.is_irq ? irq_req : bus_rdata;
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s: %s actual=%h expected=%h", it.tag,
                 it.is_irq ? "irq_req" : "bus_rdata", act, it.exp);
      end
    end
  end

  // Driver side: queue an expectation for the coming falling edge
  task automatic expect_now(bit is_irq, logic [1:0] addr, logic [7:0] exp, string tag);
    exp_item_t it;
    bus_addr = addr;
    it.is_irq = is_irq;
    it.exp = exp;
    it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    #1;
  endtask

  task automatic expect_rd(logic [1:0] addr, logic [7:0] exp, string tag);
    expect_now(1'b0, addr, exp, tag);
  endtask

  task automatic expect_irq(logic [7:0] exp, string tag);
    expect_now(1'b1, bus_addr, exp, tag);
  endtask

  task automatic wr(logic [1:0] addr, logic [7:0] data);
    @(posedge clk); #1;
    bus_we = 1'b1; bus_addr = addr; bus_wdata = data;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic xfer(logic [2:0] ch);
    @(posedge clk); #1;
    xfer_done = 1'b1; xfer_chan = ch;
    @(posedge clk); #1;
    xfer_done = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    expect_rd(2'd1, 8'h00, "R1 flags in reset");
    expect_rd(2'd0, 8'h00, "R1 enables in reset");
    expect_rd(2'd2, 8'h00, "R1 select in reset");
    expect_irq(8'h00, "R1 requests in reset");
    rst_n = 1'b1;
    settle();
    expect_rd(2'd1, 8'h00, "R2 inactive level sets nothing");

    // ch0 low, ch1 high, ch2 rise, ch3 fall; ch4..7 rise
    wr(2'd2, 8'hE4);
    wr(2'd3, 8'hAA);
    expect_rd(2'd2, 8'hE4, "R9 select byte 0 readback");
    expect_rd(2'd3, 8'hAA, "R9 select byte 1 readback");
    settle();
    expect_rd(2'd1, 8'h02, "R2 high level sets flag");

    irq_pin[7:4] = 4'h0;
    settle();
    expect_rd(2'd1, 8'h02, "R3 falling edge ignored in rise mode");

    wr(2'd1, 8'hFD);
    expect_rd(2'd1, 8'h02, "R2 level re-sets after clear");

    irq_pin[1] = 1'b0;
    settle();
    wr(2'd1, 8'hFD);
    expect_rd(2'd1, 8'h00, "R5 write 0 clears");

    irq_pin[3] = 1'b0;
    settle();
    expect_rd(2'd1, 8'h08, "R3 falling edge mode");
    irq_pin[2] = 1'b0;
    settle();
    irq_pin[2] = 1'b1;
    settle();
    expect_rd(2'd1, 8'h0C, "R3 rising edge mode");
    settle();
    expect_rd(2'd1, 8'h0C, "R4 flags hold");

    wr(2'd1, 8'hFB);
    expect_rd(2'd1, 8'h08, "R5 write 1 keeps, write 0 clears");

    wr(2'd0, 8'h0C);
    expect_rd(2'd0, 8'h0C, "R9 enable readback");
    expect_irq(8'h08, "R8 request needs flag and enable");

    xfer(3'd3);
    expect_rd(2'd1, 8'h00, "R6 transfer clears its channel");
    expect_irq(8'h00, "R8 request drops with flag");
    xfer(3'd5);
    expect_rd(2'd1, 8'h00, "R6 transfer on idle channel");

    irq_pin[0] = 1'b0;
    settle();
    expect_rd(2'd1, 8'h01, "R2 low level sets flag");
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h00);
    expect_irq(8'h01, "R7 set beats software clear");
    xfer(3'd0);
    expect_irq(8'h01, "R7 set beats transfer clear");
    irq_pin[0] = 1'b1;
    settle();
    wr(2'd1, 8'hFE);
    expect_rd(2'd1, 8'h00, "R5 clear after level removed");

    // Rising edge on ch4 lands on the same edge as its transfer clear
    @(posedge clk); #1;
    irq_pin[4] = 1'b1;
    @(posedge clk); #1;
    @(posedge clk); #1;
    xfer_done = 1'b1; xfer_chan = 3'd4;
    @(posedge clk); #1;
    xfer_done = 1'b0;
    expect_rd(2'd1, 8'h10, "R7 edge set beats transfer clear");
    wr(2'd1, 8'hEF);
    expect_rd(2'd1, 8'h00, "R5 clear ch4");

    wr(2'd0, 8'h40);
    @(posedge clk); #1;
    irq_pin[6] = 1'b1;
    @(posedge clk);
    @(posedge clk); #1;
    expect_irq(8'h00, "R10 no effect before third edge");
    expect_irq(8'h40, "R10 flag at third edge");
    wr(2'd0, 8'h00);
    expect_irq(8'h00, "R8 disabled channel gives no request");
    expect_rd(2'd1, 8'h40, "R8 flag kept while disabled");

    @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule